// File: doc/BRIEF.md
# Virtual interrupt CPU interface controller

This block is the control and acknowledge logic that a virtual machine sees in place of a physical interrupt CPU interface. A small table of list entries, four by default, holds the interrupts that the hypervisor has handed to the virtual machine. Each entry carries an interrupt ID, a group bit, a priority and a two-bit state. The block picks the best pending entry and compares its group priority against the running priority. It then drives a virtual IRQ or FIQ line, answers acknowledge and highest-pending reads, and keeps a stack of active priorities.

Software inside the virtual machine talks to the block through a word-indexed register bus. A read of the acknowledge register moves the chosen entry from pending to active and pushes its group priority. An end-of-interrupt write pops that priority. Depending on a control bit, the same write either also deactivates the interrupt, or leaves deactivation to a separate register. Every deactivation clears the active state of the matching entry and pulses a completion output that carries the interrupt ID. The hypervisor fills entries through a plain load port.

Top module: `vcpu_if_ctrl`

## Requirements
- R1: The control register (bus index 0) holds Group 0 enable at bit 0, Group 1 enable at bit 1, acknowledge control at bit 2, FIQ enable at bit 3, common binary point at bit 4 and EOI mode at bit 9. All of them reset to 0. Every other bit reads 0 and ignores writes, so writing all ones reads back 0x0000021F.
- R2: Only entries in the pending state (state code 1) whose group is enabled are candidates. The highest-pending register (index 4) returns the ID of the candidate with the lowest priority value, and ties go to the lowest entry index. With no candidate it returns 1023. Entries that are invalid (0), active (2) or pending-and-active (3) are never candidates.
- R3: The best candidate is signalled only if its group priority is numerically below the running priority. The group priority is the priority ANDed with 0xFF shifted left by (binary point + 1), truncated to 8 bits. The running priority is the top of the active-priority stack, or 0xFF when the stack is empty.
- R4: The binary-point register (index 1) and the aliased binary-point register (index 5) are 3 bits each and reset to 0. When common binary point is 0, Group 0 uses the binary-point register and Group 1 uses the aliased one. When it is 1, both groups use the binary-point register.
- R5: A signalled Group 0 interrupt drives vfiq_o when FIQ enable is 1 and virq_o when it is 0. A signalled Group 1 interrupt always drives virq_o. The two lines are never high together.
- R6: A group whose enable bit is 0 raises neither line.
- R7: A read of the acknowledge register (index 2) with a signalled interrupt returns its ID, moves the entry from pending to active and pushes its group priority. With nothing signalled the read returns 1023 and changes nothing.
- R8: When acknowledge control is 0 and the best candidate is Group 1, reads of the acknowledge and highest-pending registers return 1022 and acknowledge nothing. When it is 1, they return the real ID.
- R9: With EOI mode 0, a write of an ID to the end-of-interrupt register (index 3) or the aliased end-of-interrupt register (index 6) pops the active-priority stack and deactivates that ID.
- R10: With EOI mode 1, those writes only pop the stack. A write of an ID to the deactivate register (index 7) deactivates it.
- R11: With EOI mode 0, a write to the deactivate register changes no entry and gives no completion.
- R12: A deactivation acts on the lowest-index entry that has the written ID and the active bit (state bit 1) set. It clears that bit, so an active entry becomes invalid and a pending-and-active entry becomes pending. In the cycle after the write, done_o is high for one cycle with done_id_o equal to the ID. A deactivation that matches no entry gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; acknowledge side effects happen on the clock edge |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| ld_wr_i | input | 1 | List entry load strobe |
| ld_idx_i | input | IDX_W (2) | Entry index to load |
| ld_id_i | input | ID_W (10) | Interrupt ID to load |
| ld_grp_i | input | 1 | Group bit to load |
| ld_prio_i | input | PRIO_W (8) | Priority to load |
| ld_state_i | input | 2 | State to load: 0 invalid, 1 pending, 2 active, 3 pending-and-active |
| virq_o | output | 1 | Virtual IRQ line |
| vfiq_o | output | 1 | Virtual FIQ line |
| done_o | output | 1 | Deactivation completion pulse |
| done_id_o | output | ID_W (10) | ID of the deactivated interrupt |

## Verification
The bench builds the block with its defaults: four list entries, 10-bit IDs and 8-bit priorities. With four entries, sixteen group and priority patterns cover every group mix and many priority ties for the selection. All sixteen combinations of the two enables, acknowledge control and FIQ enable are swept for both groups. With 8-bit priorities, every binary-point setting can be crossed with both groups, both common-binary-point settings and sixteen priority steps against a fixed running priority, and that includes the equality boundary.

// File: rtl/vcpu_if_pkg.sv
package vcpu_if_pkg;
  localparam logic [1:0] ST_INV  = 2'd0;
  localparam logic [1:0] ST_PEND = 2'd1;
  localparam logic [1:0] ST_ACT  = 2'd2;
  localparam logic [1:0] ST_PACT = 2'd3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_BPR   = 3'd1;
  localparam logic [2:0] A_IAR   = 3'd2;
  localparam logic [2:0] A_EOI   = 3'd3;
  localparam logic [2:0] A_HPPI  = 3'd4;
  localparam logic [2:0] A_ABPR  = 3'd5;
  localparam logic [2:0] A_AEOI  = 3'd6;
  localparam logic [2:0] A_DIR   = 3'd7;

  localparam int C_EN0  = 0;
  localparam int C_EN1  = 1;
  localparam int C_ACK  = 2;
  localparam int C_FIQ  = 3;
  localparam int C_CBPR = 4;
  localparam int C_EOIM = 9;
  localparam logic [31:0] CTRL_MASK = 32'h0000_021F;
endpackage

// File: rtl/vcpu_lr_file.sv
module vcpu_lr_file import vcpu_if_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ld_wr_i,
  input  logic [IDX_W-1:0]               ld_idx_i,
  input  logic [ID_W-1:0]                ld_id_i,
  input  logic                           ld_grp_i,
  input  logic [PRIO_W-1:0]              ld_prio_i,
  input  logic [1:0]                     ld_state_i,
  input  logic                           ack_i,
  input  logic [IDX_W-1:0]               ack_idx_i,
  input  logic                           deact_i,
  input  logic [ID_W-1:0]                deact_id_i,
  output logic [NUM_LR-1:0][ID_W-1:0]    id_o,
  output logic [NUM_LR-1:0]              grp_o,
  output logic [NUM_LR-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_LR-1:0][1:0]         state_o,
  output logic                           done_o,
  output logic [ID_W-1:0]                done_id_o
);
  logic [NUM_LR-1:0][ID_W-1:0]   id_q;
  logic [NUM_LR-1:0]             grp_q;
  logic [NUM_LR-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_LR-1:0][1:0]        state_q;
  logic                          hit;
  logic [IDX_W-1:0]              hit_idx;
  logic                          done_q;
  logic [ID_W-1:0]               done_id_q;

  // lowest-index active entry carrying the ID
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (!hit && state_q[i][1] && id_q[i] == deact_id_i) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q      <= '0;
      grp_q     <= '0;
      prio_q    <= '0;
      state_q   <= '0;
      done_q    <= 1'b0;
      done_id_q <= '0;
    end else begin
      if (ack_i) state_q[ack_idx_i] <= ST_ACT;
      if (deact_i && hit) state_q[hit_idx] <= {1'b0, state_q[hit_idx][0]};
      if (ld_wr_i) begin
        id_q[ld_idx_i]    <= ld_id_i;
        grp_q[ld_idx_i]   <= ld_grp_i;
        prio_q[ld_idx_i]  <= ld_prio_i;
        state_q[ld_idx_i] <= ld_state_i;
      end
      done_q    <= deact_i && hit;
      done_id_q <= deact_id_i;
    end
  end

  assign id_o      = id_q;
  assign grp_o     = grp_q;
  assign prio_o    = prio_q;
  assign state_o   = state_q;
  assign done_o    = done_q;
  assign done_id_o = done_id_q;
endmodule

// File: rtl/vcpu_hppi_sel.sv
module vcpu_hppi_sel import vcpu_if_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic [NUM_LR-1:0][1:0]        state_i,
  input  logic [NUM_LR-1:0]             grp_i,
  input  logic [NUM_LR-1:0][PRIO_W-1:0] prio_i,
  input  logic [1:0]                    grp_en_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [NUM_LR-1:0] elig;
  logic [PRIO_W-1:0] best;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_elig
    assign elig[g] = (state_i[g] == ST_PEND) && grp_en_i[grp_i[g]];
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (elig[i] && (!found_o || prio_i[i] < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vcpu_prio_stack.sv
module vcpu_prio_stack #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_val_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] rpr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [DEPTH-1:0][PRIO_W-1:0] mem_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             top_c;

  assign top_c  = cnt_q - CNT_W'(1);
  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign rpr_o  = (cnt_q == '0) ? '1 : mem_q[top_c[IDX_W-1:0]];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      mem_q[cnt_q[IDX_W-1:0]] <= push_val_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= top_c;
    end
  end
endmodule

// File: rtl/vcpu_if_ctrl.sv
module vcpu_if_ctrl import vcpu_if_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_LR),
  localparam int BP_W  = $clog2(PRIO_W),
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ld_wr_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ID_W-1:0]   ld_id_i,
  input  logic              ld_grp_i,
  input  logic [PRIO_W-1:0] ld_prio_i,
  input  logic [1:0]        ld_state_i,
  output logic              virq_o,
  output logic              vfiq_o,
  output logic              done_o,
  output logic [ID_W-1:0]   done_id_o
);
  localparam logic [ID_W-1:0] ID_G1_SPUR = ID_W'(1022);
  localparam logic [ID_W-1:0] ID_NONE    = ID_W'(1023);

  logic [31:0]                   ctrl_q;
  logic [BP_W-1:0]               bpr_q, abpr_q;
  logic [NUM_LR-1:0][ID_W-1:0]   lr_id;
  logic [NUM_LR-1:0]             lr_grp;
  logic [NUM_LR-1:0][PRIO_W-1:0] lr_prio;
  logic [NUM_LR-1:0][1:0]        lr_state;
  logic                          hp_found;
  logic [IDX_W-1:0]              hp_idx;
  logic                          hp_grp;
  logic [BP_W-1:0]               eff_bp;
  logic [PRIO_W:0]               gp_wide;
  logic [PRIO_W-1:0]             hp_gp;
  logic [PRIO_W-1:0]             rpr;
  logic [CNT_W-1:0]              stk_cnt;
  logic                          stk_full;
  logic                          signal, g1_block, can_ack;
  logic                          stk_push, stk_pop, deact;
  logic                          wr_eoi, wr_dir;
  logic [ID_W-1:0]               iar_val, hppi_val;

  vcpu_hppi_sel #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) sel_i (
    .state_i (lr_state),
    .grp_i   (lr_grp),
    .prio_i  (lr_prio),
    .grp_en_i({ctrl_q[C_EN1], ctrl_q[C_EN0]}),
    .found_o (hp_found),
    .idx_o   (hp_idx)
  );

  assign hp_grp  = lr_grp[hp_idx];
  assign eff_bp  = (hp_grp && !ctrl_q[C_CBPR]) ? abpr_q : bpr_q;
  assign gp_wide = {(PRIO_W+1){1'b1}} << (32'(eff_bp) + 32'd1);
  assign hp_gp   = lr_prio[hp_idx] & gp_wide[PRIO_W-1:0];

  assign signal   = hp_found && (hp_gp < rpr);
  assign g1_block = hp_grp && !ctrl_q[C_ACK];
  assign can_ack  = signal && !stk_full;
  assign virq_o   = signal && (hp_grp || !ctrl_q[C_FIQ]);
  assign vfiq_o   = signal && !hp_grp && ctrl_q[C_FIQ];

  assign iar_val  = !can_ack  ? ID_NONE : g1_block ? ID_G1_SPUR : lr_id[hp_idx];
  assign hppi_val = !hp_found ? ID_NONE : g1_block ? ID_G1_SPUR : lr_id[hp_idx];

  assign stk_push = bus_rd_i && bus_addr_i == A_IAR && can_ack && !g1_block;
  assign wr_eoi   = bus_wr_i && (bus_addr_i == A_EOI || bus_addr_i == A_AEOI);
  assign wr_dir   = bus_wr_i && bus_addr_i == A_DIR;
  assign stk_pop  = wr_eoi;
  assign deact    = ctrl_q[C_EOIM] ? wr_dir : wr_eoi;

  vcpu_prio_stack #(.DEPTH(NUM_LR), .PRIO_W(PRIO_W)) stk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (stk_push),
    .push_val_i(hp_gp),
    .pop_i     (stk_pop),
    .rpr_o     (rpr),
    .cnt_o     (stk_cnt),
    .full_o    (stk_full)
  );

  vcpu_lr_file #(.NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W)) lr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_wr_i   (ld_wr_i),
    .ld_idx_i  (ld_idx_i),
    .ld_id_i   (ld_id_i),
    .ld_grp_i  (ld_grp_i),
    .ld_prio_i (ld_prio_i),
    .ld_state_i(ld_state_i),
    .ack_i     (stk_push),
    .ack_idx_i (hp_idx),
    .deact_i   (deact),
    .deact_id_i(bus_wdata_i[ID_W-1:0]),
    .id_o      (lr_id),
    .grp_o     (lr_grp),
    .prio_o    (lr_prio),
    .state_o   (lr_state),
    .done_o    (done_o),
    .done_id_o (done_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      bpr_q  <= '0;
      abpr_q <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        A_CTRL:  ctrl_q <= bus_wdata_i & CTRL_MASK;
        A_BPR:   bpr_q  <= bus_wdata_i[BP_W-1:0];
        A_ABPR:  abpr_q <= bus_wdata_i[BP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl_q;
      A_BPR:   bus_rdata_o = 32'(bpr_q);
      A_ABPR:  bus_rdata_o = 32'(abpr_q);
      A_IAR:   bus_rdata_o = 32'(iar_val);
      A_HPPI:  bus_rdata_o = 32'(hppi_val);
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vcpu_if_ctrl_chk.sv
module vcpu_if_ctrl_chk #(
  parameter int NUM_LR = 4,
  parameter int PRIO_W = 8,
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [2:0]        bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              virq_o,
  input logic              vfiq_o,
  input logic              done_o,
  input logic              eoi_mode,
  input logic [CNT_W-1:0]  stk_cnt,
  input logic              stk_push,
  input logic [PRIO_W-1:0] rpr
);
  AST_CTRL_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == 3'd0 |-> (bus_rdata_o & ~32'h0000_021F) == 32'd0); // R1
  AST_PUSH_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_push |=> rpr < $past(rpr)); // R3
  AST_LINES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(virq_o && vfiq_o)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_cnt <= CNT_W'(NUM_LR)); // R7
  AST_SPUR_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == 3'd2 && bus_rdata_o == 32'd1022 |=> stk_cnt == $past(stk_cnt)); // R8
  AST_DROP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 3'd3 && eoi_mode |=> !done_o); // R10
  AST_DIR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 3'd7 && !eoi_mode |=> !done_o); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_wr_i)); // R12
endmodule

bind vcpu_if_ctrl vcpu_if_ctrl_chk #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .virq_o     (virq_o),
  .vfiq_o     (vfiq_o),
  .done_o     (done_o),
  .eoi_mode   (ctrl_q[9]),
  .stk_cnt    (stk_cnt),
  .stk_push   (stk_push),
  .rpr        (rpr)
);

// File: tb/vcpu_if_ctrl_tb_top.sv
module vcpu_if_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ld = 1'b0;
  logic [1:0]  ld_idx = '0;
  logic [9:0]  ld_id = '0;
  logic        ld_grp = 1'b0;
  logic [7:0]  ld_prio = '0;
  logic [1:0]  ld_st = '0;
  logic        virq, vfiq, done;
  logic [9:0]  done_id;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcpu_if_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ld_wr_i(ld), .ld_idx_i(ld_idx),
    .ld_id_i(ld_id), .ld_grp_i(ld_grp), .ld_prio_i(ld_prio), .ld_state_i(ld_st),
    .virq_o(virq), .vfiq_o(vfiq), .done_o(done), .done_id_o(done_id)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic lrl(input int idx, input int id, input int grp, input int prio, input int st);
    @(negedge clk); ld = 1'b1; ld_idx = 2'(idx); ld_id = 10'(id);
    ld_grp = grp[0]; ld_prio = 8'(prio); ld_st = 2'(st);
    @(posedge clk); #1 ld = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired got=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    brd(3'd0, r); chk("R1 ctrl reset", r, 32'h0);
    chk("R6 virq reset", 32'(virq), 32'd0);
    chk("R6 vfiq reset", 32'(vfiq), 32'd0);
    brd(3'd4, r); chk("R2 hppi empty", r, 32'd1023);
    brd(3'd2, r); chk("R7 iar empty", r, 32'd1023);
    brd(3'd1, r); chk("R4 bpr reset", r, 32'd0);

    // R1 reserved bits
    bwr(3'd0, 32'hFFFF_FFFF); brd(3'd0, r); chk("R1 ctrl ones", r, 32'h21F);
    bwr(3'd0, 32'h0); brd(3'd0, r); chk("R1 ctrl zero", r, 32'h0);

    // R5 R6: routing and gating sweep
    for (int g = 0; g < 2; g++) begin
      lrl(0, 10 + g, g, 16, 1);
      for (int c = 0; c < 16; c++) begin
        bit en, ei, ef;
        bwr(3'd0, 32'(c));
        en = (g == 1) ? c[1] : c[0];
        ei = en && (g == 1 || !c[3]);
        ef = en && g == 0 && c[3];
        chk("R5 R6 virq", 32'(virq), 32'(ei));
        chk("R5 R6 vfiq", 32'(vfiq), 32'(ef));
      end
    end
    lrl(0, 0, 0, 0, 0);

    // R2: selection sweep
    for (int k = 0; k < 16; k++) begin
      int pr[4];
      int gr[4];
      for (int i = 0; i < 4; i++) begin
        pr[i] = ((k * 37 + i * 53) % 4) * 16;
        gr[i] = (k >> i) & 1;
        lrl(i, 100 + i, gr[i], pr[i], 1);
      end
      for (int m = 0; m < 2; m++) begin
        int best;
        best = -1;
        bwr(3'd0, (m == 0) ? 32'h5 : 32'h7);
        for (int i = 0; i < 4; i++)
          if ((m == 1 || gr[i] == 0) && (best < 0 || pr[i] < pr[best])) best = i;
        brd(3'd4, r);
        chk("R2 hppi select", r, (best < 0) ? 32'd1023 : 32'(100 + best));
      end
    end
    for (int i = 0; i < 4; i++) lrl(i, 0, 0, 0, 0);

    // R3 R4 R7: binary point sweep against a running priority of 0x80
    bwr(3'd0, 32'h7);
    bwr(3'd1, 32'h0);
    lrl(0, 50, 0, 8'h80, 1);
    brd(3'd2, r); chk("R7 iar ack", r, 32'd50);
    brd(3'd4, r); chk("R7 entry now active", r, 32'd1023);
    for (int c = 0; c < 2; c++) begin
      bwr(3'd0, 32'h7 | (32'(c) << 4));
      for (int b = 0; b < 8; b++) begin
        bwr(3'd1, 32'(b));
        bwr(3'd5, 32'(7 - b));
        brd(3'd1, r); chk("R4 bpr readback", r, 32'(b));
        for (int g = 0; g < 2; g++) begin
          for (int p = 0; p < 256; p += 16) begin
            int eff, msk;
            lrl(1, 60, g, p, 1);
            eff = (g == 0 || c == 1) ? b : 7 - b;
            msk = (32'h1FF << (eff + 1)) & 32'hFF;
            chk("R3 R4 gp vs running", 32'(virq), 32'((p & msk) < 8'h80));
          end
        end
      end
    end
    lrl(1, 0, 0, 0, 0);
    bwr(3'd1, 32'h0);
    bwr(3'd0, 32'h7);

    // R9: combined drop and deactivate
    bwr(3'd3, 32'd50);
    chk("R9 done pulse", 32'(done), 32'd1);
    chk("R9 done id", 32'(done_id), 32'd50);
    @(posedge clk); #1 chk("R12 pulse one cycle", 32'(done), 32'd0);
    lrl(1, 61, 0, 8'hF0, 1);
    chk("R9 running dropped", 32'(virq), 32'd1);
    brd(3'd2, r); chk("R7 iar second", r, 32'd61);
    bwr(3'd6, 32'd61);
    chk("R9 aliased eoi done", 32'(done), 32'd1);
    chk("R9 aliased eoi id", 32'(done_id), 32'd61);
    brd(3'd2, r); chk("R7 iar none", r, 32'd1023);

    // R8: group 1 acknowledge control
    bwr(3'd0, 32'h3);
    lrl(2, 70, 1, 8'h20, 1);
    brd(3'd4, r); chk("R8 hppi spurious", r, 32'd1022);
    brd(3'd2, r); chk("R8 iar spurious", r, 32'd1022);
    brd(3'd4, r); chk("R8 not acked", r, 32'd1022);
    chk("R5 group1 on irq", 32'(virq), 32'd1);
    bwr(3'd0, 32'h7);
    brd(3'd2, r); chk("R8 iar real id", r, 32'd70);
    brd(3'd4, r); chk("R8 acked", r, 32'd1023);
    chk("R7 no pending no irq", 32'(virq), 32'd0);
    bwr(3'd3, 32'd70);
    chk("R9 done group1", 32'(done), 32'd1);

    // R10: split mode
    bwr(3'd0, 32'h207);
    lrl(0, 80, 0, 8'h40, 1);
    brd(3'd2, r); chk("R10 iar", r, 32'd80);
    bwr(3'd3, 32'd80);
    chk("R10 eoi no deactivate", 32'(done), 32'd0);
    lrl(1, 81, 0, 8'h60, 1);
    chk("R10 eoi drops priority", 32'(virq), 32'd1);
    bwr(3'd7, 32'd80);
    chk("R10 dir done", 32'(done), 32'd1);
    chk("R10 dir id", 32'(done_id), 32'd80);
    bwr(3'd7, 32'd80);
    chk("R12 no match no pulse", 32'(done), 32'd0);
    lrl(1, 0, 0, 0, 0);

    // R11: deactivate register ignored in combined mode
    bwr(3'd0, 32'h7);
    lrl(0, 90, 0, 8'h40, 1);
    brd(3'd2, r); chk("R11 iar", r, 32'd90);
    bwr(3'd7, 32'd90);
    chk("R11 dir no done", 32'(done), 32'd0);
    bwr(3'd3, 32'd90);
    chk("R11 entry kept active", 32'(done), 32'd1);
    chk("R11 eoi id", 32'(done_id), 32'd90);

    // R12: pending-and-active entry
    bwr(3'd0, 32'h207);
    lrl(3, 77, 0, 8'h30, 3);
    brd(3'd4, r); chk("R12 pend-act not candidate", r, 32'd1023);
    bwr(3'd7, 32'd77);
    chk("R12 pend-act done", 32'(done), 32'd1);
    chk("R12 pend-act id", 32'(done_id), 32'd77);
    brd(3'd4, r); chk("R12 becomes pending", r, 32'd77);

    finish_run();
  end
endmodule